// File: doc/BRIEF.md
# Two-Level Interrupt Control Register

This block is the interrupt control and status register of a small microcontroller core, together with the logic that forms the single interrupt request to the core. The 8-bit register holds five enables and three source flags. The enables are a master enable, an enable for the whole peripheral group, and one enable each for a timer overflow source, an external pin source and a pin-change source. The flags record timer overflow, external pin events and pin changes.

The timer and external flags are sticky. A single-cycle pulse from the source sets them, whatever the enables are, and they stay set until software writes 0. The pin-change flag cannot be written. It is a registered OR of a vector of per-pin change flags that are held elsewhere, so it clears only after software has cleared every one of those per-pin flags. The peripheral group arrives as one summary request. It reaches the core only when both the peripheral enable and the master enable are set.

Top module: `irq_ctrl_reg`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `rd_data` reads 8'h00 and `irq_req` is 0.
- R2: The register layout, from bit 7 down to bit 0, is: master enable, peripheral enable, timer enable, external enable, pin-change enable, timer flag, external flag, pin-change flag.
- R3: A write (`wr_en` high at a rising edge) loads `wr_data[7:1]` into bits 7 to 1. The new value reads back on `rd_data` from that edge onward.
- R4: Bit 0 ignores CPU writes. Writing 1 does not set it, and writing 0 does not clear it while any per-pin change flag is set.
- R5: A pulse on `tmr_ovf_pulse` sets bit 2, and a pulse on `ext_evt_pulse` sets bit 1, at the next edge, whatever the values of bits 7 to 3.
- R6: Bits 2 and 1, once set, stay at 1 until a write puts 0 in them.
- R7: If a source pulse and a CPU write of 0 to the same flag fall on the same edge, the flag is 1 after that edge.
- R8: Bit 0 is 1 one edge after at least one bit of `chg_flags` is 1. It returns to 0 one edge after all bits of `chg_flags` are 0.
- R9: `irq_req` = bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND `periph_req`)). When bit 7 is 0, `irq_req` is 0.
- R10: `periph_req` raises `irq_req` only when bits 7 and 6 are both 1. It does so combinationally, in the same cycle.
- R11: If a write sets an enable over a flag that is already pending, `irq_req` rises right after that write edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Current register contents |
| tmr_ovf_pulse | input | 1 | Single-cycle timer overflow event |
| ext_evt_pulse | input | 1 | Single-cycle external pin event (already edge-detected) |
| chg_flags | input | CHG_PINS | Per-pin change flags held elsewhere |
| periph_req | input | 1 | Summary request of the peripheral group |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The bench pulses each source while all enables are 0. A design that gates flag setting with the enables would read 0 in the flag bits. The bench then turns on the matching enable over a flag that is already set, and checks `irq_req` in the cycle right after the write. A design that samples only new events, or that adds a register stage, would miss this or report it late. It writes 1 and 0 to bit 0 while holding the per-pin flags steady; a design that treats bit 0 as writable would follow the write instead of the pins. It also lands a source pulse on the same edge as a clearing write, where a design that lets the write win would drop the event. Finally, it steps the peripheral request through the three enable combinations, where a design that ignored the peripheral enable would raise the request too early.

// File: rtl/irq_ctl_pkg.sv
// Shared layout of the interrupt control register.
// Assumes an 8-bit register; the field order is visible to software.
package irq_ctl_pkg;

    localparam int REG_W = 8;

    // Field view of the register, most significant bit first.
    typedef struct packed {
        logic master_en;
        logic periph_en;
        logic tmr_en;
        logic ext_en;
        logic chg_en;
        logic tmr_flag;
        logic ext_flag;
        logic chg_flag;
    } irq_ctl_t;

    localparam int EN_W  = 5;   // writable enables, bits 7..3
    localparam int HWF_W = 2;   // sticky hardware flags, bits 2..1

endpackage

// File: rtl/irq_enable_bank.sv
// Holds the writable enable bits. Plain storage loaded by CPU writes.
// Assumes the write strobe and data are synchronous to clk.
module irq_enable_bank #(
    parameter int EN_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [EN_W-1:0] wr_bits,
    output logic [EN_W-1:0] en_q
);

    // Load the enables on a write, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wr_bits;
    end

endmodule

// File: rtl/irq_flag_bank.sv
// Sticky event flags. A source pulse sets a flag whatever the enables are.
// A CPU write loads the flag, but a pulse on the same edge wins.
// Assumes the set pulses are single-cycle and synchronous to clk.
module irq_flag_bank #(
    parameter int NUM_FLAGS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_FLAGS-1:0] wr_bits,
    input  logic [NUM_FLAGS-1:0] set_pulse,
    output logic [NUM_FLAGS-1:0] flag_q
);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        // One sticky flag: a set event takes priority over a write.
        always_ff @(posedge clk) begin
            if (!rst_n)            flag_q[i] <= 1'b0;
            else if (set_pulse[i]) flag_q[i] <= 1'b1;
            else if (wr_en)        flag_q[i] <= wr_bits[i];
        end
    end

endmodule

// File: rtl/irq_chg_summary.sv
// Read-only summary of the per-pin change flags, registered once.
// Assumes the per-pin flags are held and cleared by their own registers.
module irq_chg_summary #(
    parameter int CHG_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHG_PINS-1:0] pin_flags,
    output logic                any_q
);

    // Track whether any per-pin flag is still set.
    always_ff @(posedge clk) begin
        if (!rst_n) any_q <= 1'b0;
        else        any_q <= |pin_flags;
    end

endmodule

// File: rtl/irq_req_gen.sv
// Two-level request gating: the source terms are ORed, the peripheral
// term also needs its group enable, and the master enable gates the result.
// Purely combinational; no added latency.
module irq_req_gen (
    input  irq_ctl_pkg::irq_ctl_t ctl,
    input  logic                  periph_req,
    output logic                  irq_req
);

    logic src_any;

    // Form the request from the enabled sources.
    always_comb begin
        src_any = (ctl.tmr_en    & ctl.tmr_flag)
                | (ctl.ext_en    & ctl.ext_flag)
                | (ctl.chg_en    & ctl.chg_flag)
                | (ctl.periph_en & periph_req);
        irq_req = ctl.master_en & src_any;
    end

endmodule

// File: rtl/irq_ctrl_reg.sv
// Interrupt control/status register with its request logic.
// Bits 7..3 are enables, 2..1 are sticky flags and 0 is a read-only summary.
// Assumes single-cycle event pulses and a synchronous active-low reset.
module irq_ctrl_reg
    import irq_ctl_pkg::*;
#(
    parameter int CHG_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    input  logic                tmr_ovf_pulse,
    input  logic                ext_evt_pulse,
    input  logic [CHG_PINS-1:0] chg_flags,
    input  logic                periph_req,
    output logic                irq_req
);

    localparam int HWF_LSB = 1;
    localparam int EN_LSB  = HWF_LSB + HWF_W;

    logic [EN_W-1:0]  en_q;
    logic [HWF_W-1:0] hwf_q;
    logic             chg_q;
    irq_ctl_t         ctl;

    irq_enable_bank #(.EN_W(EN_W)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bits (wr_data[EN_LSB +: EN_W]),
        .en_q    (en_q)
    );

    irq_flag_bank #(.NUM_FLAGS(HWF_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_bits   (wr_data[HWF_LSB +: HWF_W]),
        .set_pulse ({tmr_ovf_pulse, ext_evt_pulse}),
        .flag_q    (hwf_q)
    );

    irq_chg_summary #(.CHG_PINS(CHG_PINS)) u_chg (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_flags (chg_flags),
        .any_q     (chg_q)
    );

    // Assemble the register view from its parts.
    always_comb begin
        ctl     = irq_ctl_t'({en_q, hwf_q, chg_q});
        rd_data = ctl;
    end

    irq_req_gen u_req (
        .ctl        (ctl),
        .periph_req (periph_req),
        .irq_req    (irq_req)
    );

endmodule

// File: rtl/irq_ctrl_reg_chk.sv
// Checker for irq_ctrl_reg, attached with bind below.
module irq_ctrl_reg_chk #(
    parameter int CHG_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [7:0]          wr_data,
    input logic [7:0]          rd_data,
    input logic                tmr_ovf_pulse,
    input logic                ext_evt_pulse,
    input logic [CHG_PINS-1:0] chg_flags,
    input logic                periph_req,
    input logic                irq_req
);

    logic live;

    // Marks the cycles after the first edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // R9
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[7] |-> !irq_req);

    // R10
    periph_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_req && rd_data[7] && rd_data[6]) |-> irq_req);

    // R7
    tmr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(tmr_ovf_pulse)) |-> rd_data[2]);

    // R6
    tmr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2] && !(wr_en && !wr_data[2])) |=> rd_data[2]);

    // R4
    chg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (rd_data[0] == $past(|chg_flags)));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 8'h00));

endmodule

bind irq_ctrl_reg irq_ctrl_reg_chk #(.CHG_PINS(CHG_PINS)) u_irq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .tmr_ovf_pulse (tmr_ovf_pulse),
    .ext_evt_pulse (ext_evt_pulse),
    .chg_flags     (chg_flags),
    .periph_req    (periph_req),
    .irq_req       (irq_req)
);

// File: tb/test_irq_ctrl_reg.sv
`timescale 1ns/1ps
module test_irq_ctrl_reg;

    localparam int PINS = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [7:0]      wr_data = '0;
    logic [7:0]      rd_data;
    logic            tmr_ovf_pulse = 1'b0;
    logic            ext_evt_pulse = 1'b0;
    logic [PINS-1:0] chg_flags = '0;
    logic            periph_req = 1'b0;
    logic            irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctrl_reg #(.CHG_PINS(PINS)) i_irq_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tmr_ovf_pulse(tmr_ovf_pulse),
        .ext_evt_pulse(ext_evt_pulse), .chg_flags(chg_flags),
        .periph_req(periph_req), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One rising edge; inputs change and outputs are sampled at falling edges.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        step(); step();
        chk("R1 reset rd", rd_data, 8'h00);
        chk("R1 reset irq", {7'd0, irq_req}, 8'h00);
        rst_n = 1'b1;
        step();
        chk("R1 first cycle", rd_data, 8'h00);
    endtask

    task automatic t_rw();
        write(8'hFF);
        chk("R3 R4 write FF", rd_data, 8'hFE);
        chk("R9 all enabled", {7'd0, irq_req}, 8'h01);
        write(8'h00);
        chk("R3 write 00", rd_data, 8'h00);
        chk("R9 idle", {7'd0, irq_req}, 8'h00);
        write(8'h20);   // R2: timer enable alone at bit 5
        chk("R2 bit5 position", rd_data, 8'h20);
        write(8'h00);
    endtask

    task automatic t_bit0();
        write(8'h01);
        chk("R4 write 1 to bit0", rd_data, 8'h00);
        chg_flags = 4'b0010;
        step();
        chk("R8 pin set", rd_data, 8'h01);
        write(8'h00);
        chk("R4 write 0 to bit0", rd_data, 8'h01);
        chg_flags = '0;
        step();
    endtask

    task automatic t_latch();
        tmr_ovf_pulse = 1'b1; step(); tmr_ovf_pulse = 1'b0;
        chk("R5 timer flag latched", rd_data, 8'h04);
        chk("R5 no irq", {7'd0, irq_req}, 8'h00);
        ext_evt_pulse = 1'b1; step(); ext_evt_pulse = 1'b0;
        chk("R5 ext flag latched", rd_data, 8'h06);
        step(); step(); step();
        chk("R6 flags hold", rd_data, 8'h06);
        write(8'hA6);
        chk("R11 irq over pending timer", {7'd0, irq_req}, 8'h01);
        write(8'h86);
        chk("R9 no source enabled", {7'd0, irq_req}, 8'h00);
        write(8'h96);
        chk("R11 irq over pending ext", {7'd0, irq_req}, 8'h01);
        write(8'h16);
        chk("R9 master off", {7'd0, irq_req}, 8'h00);
        write(8'h00);
        chk("R6 cleared by write", rd_data, 8'h00);
    endtask

    task automatic t_race();
        tmr_ovf_pulse = 1'b1; step(); tmr_ovf_pulse = 1'b0;
        wr_en = 1'b1; wr_data = 8'h00; tmr_ovf_pulse = 1'b1;
        step();
        wr_en = 1'b0; tmr_ovf_pulse = 1'b0;
        chk("R7 set wins timer", rd_data, 8'h04);
        wr_en = 1'b1; wr_data = 8'h00; ext_evt_pulse = 1'b1;
        step();
        wr_en = 1'b0; ext_evt_pulse = 1'b0;
        chk("R7 set wins ext", rd_data, 8'h02);
        write(8'h00);
        chk("R7 clear after", rd_data, 8'h00);
    endtask

    task automatic t_chg();
        write(8'h88);
        chg_flags = 4'b1010;
        #1;
        chk("R8 one edge latency", rd_data, 8'h88);
        step();
        chk("R8 summary set", rd_data, 8'h89);
        chk("R9 change irq", {7'd0, irq_req}, 8'h01);
        chg_flags = 4'b1000;
        step();
        chk("R8 partial clear", rd_data, 8'h89);
        chg_flags = '0;
        step();
        chk("R8 all clear", rd_data, 8'h88);
        chk("R9 change irq gone", {7'd0, irq_req}, 8'h00);
        write(8'h00);
    endtask

    task automatic t_periph();
        write(8'h80);
        periph_req = 1'b1; #1;
        chk("R10 group disabled", {7'd0, irq_req}, 8'h00);
        write(8'hC0);
        chk("R10 group enabled", {7'd0, irq_req}, 8'h01);
        periph_req = 1'b0; #1;
        chk("R10 request dropped", {7'd0, irq_req}, 8'h00);
        periph_req = 1'b1;
        write(8'h40);
        chk("R10 master off", {7'd0, irq_req}, 8'h00);
        periph_req = 1'b0;
        write(8'h00);
    endtask

    initial begin
        t_reset();
        t_rw();
        t_bit0();
        t_latch();
        t_race();
        t_chg();
        t_periph();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule